// File: doc/BRIEF.md
# Edge-Triggered Timestamp Event Capture Unit

This unit records the value of a free-running 32-bit time counter at the moment a selected event edge occurs. The event comes either from an asynchronous request pin or from an internal trigger line. The unit has one capture channel. A validity flag holds a stored timestamp until the host has read it. A miss flag reports any event that arrives while a timestamp is still pending. A saturating counter tallies the events seen since the status word was last written.

The host reaches the unit through a plain 16-bit word-addressed register port. Reads are combinational from the address. A write takes effect at the clock edge on which the write strobe is high. Status word 0 holds the flags, the source select and the event counter. Words 1 and 2 hold the low and high halves of the stored timestamp. Word 3 is the capture configuration. The host re-arms the channel by writing status word 0 with the valid bit at zero.

Top module: `evcap_unit`

## Requirements
- R1: After synchronous reset, every readable word (0, 1, 2, 3) reads 0, and addresses 4 to 7 always read 0.
- R2: The configuration word is at address 3, with bit 0 = falling-edge select, bit 1 = overwrite mode and bit 2 = capture arm. When bit 2 is set and a selected edge reaches the input, the unit stores the time-counter value present at the third rising clock edge after the input change. The low half appears at address 1, the high half at address 2, and the valid flag (status bit 0) is set. Before that edge, valid is still clear.
- R3: When configuration bit 0 is clear, only rising input edges are events. When it is set, only falling input edges are events.
- R4: Status bit 2 selects the internal trigger as the event source when set. When it is clear, the request pin is the source. Edges on the source that is not selected have no effect.
- R5: A single edge followed by a held level produces exactly one event.
- R6: An event that arrives while valid is set raises the error flag (status bit 1). With overwrite mode off, the stored timestamp is kept.
- R7: With overwrite mode on, an event that arrives while valid is set replaces the stored timestamp and raises the error flag.
- R8: A write to address 0 clears valid and error where the written bit 0 or bit 1 is 0, and leaves them unchanged where the written bit is 1. Writes to addresses 1 and 2 have no effect.
- R9: Status bits 15:8 count the events seen while armed, including missed ones, and stop at 255.
- R10: Any write to address 0 clears the event counter.
- R11: While configuration bit 2 is clear, edges change neither the flags, the counter nor the timestamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_now | input | 32 | Free-running time counter to be sampled |
| ext_req | input | 1 | Asynchronous event request pin |
| int_trig | input | 1 | Internal trigger line |
| reg_addr | input | 3 | Host word address |
| reg_wr | input | 1 | Host write strobe |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data for reg_addr |

## Verification
An input change made at a falling clock edge passes two synchroniser flops. The edge detector then fires, and the state updates at the third rising edge. The bench therefore changes the time counter at every falling edge, expects the value it drove just before that third edge, and confirms that valid is still clear one cycle earlier. Register writes are strobed for one cycle and read back at the next falling edge. Read data is combinational, so each read samples 1 ns after setting the address. The bench sweeps the counter edge by edge through saturation and sweeps the timestamp capture over many counter values. All expected values are computed from the bench's own event tally.

// File: rtl/evcap_pkg.sv
package evcap_pkg;

    // host word addresses (status block order is fixed: flags, low, high)
    localparam logic [2:0] ADDR_STATUS = 3'd0;
    localparam logic [2:0] ADDR_TS_LO  = 3'd1;
    localparam logic [2:0] ADDR_TS_HI  = 3'd2;
    localparam logic [2:0] ADDR_CFG    = 3'd3;

    // status word bit positions
    localparam int ST_VALID   = 0;
    localparam int ST_ERR     = 1;
    localparam int ST_SRC_INT = 2;
    localparam int ST_CNT_LSB = 8;

    // configuration word bit positions
    localparam int CF_FALL = 0;
    localparam int CF_OVR  = 1;
    localparam int CF_ARM  = 2;

    typedef struct packed {
        logic armed;
        logic overwrite;
        logic falling;
    } cap_cfg_t;

    typedef struct packed {
        logic wr;      // host write to the status word this cycle
        logic keep_v;  // written value of the valid bit
        logic keep_e;  // written value of the error bit
    } st_wr_t;

    function automatic cap_cfg_t cfg_from_word(input logic [15:0] w);
        cap_cfg_t c;
        c.falling   = w[CF_FALL];
        c.overwrite = w[CF_OVR];
        c.armed     = w[CF_ARM];
        return c;
    endfunction

    function automatic logic [15:0] cfg_to_word(input cap_cfg_t c);
        logic [15:0] w;
        w          = '0;
        w[CF_FALL] = c.falling;
        w[CF_OVR]  = c.overwrite;
        w[CF_ARM]  = c.armed;
        return w;
    endfunction

endpackage

// File: rtl/evcap_sync_edge.sv
module evcap_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic falling,
    output logic pulse
);
    logic [STAGES-1:0] sync_q;
    logic              hist_q;
    logic              lvl;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign lvl = sync_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) hist_q <= 1'b0;
        else     hist_q <= lvl;
    end

    assign pulse = falling ? (hist_q & ~lvl) : (lvl & ~hist_q);

    // one pulse per edge: a held level never re-fires
    assert_one_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

endmodule

// File: rtl/evcap_capture.sv
module evcap_capture
    import evcap_pkg::*;
#(
    parameter int TS_W  = 32,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic             overwrite,
    input  logic [TS_W-1:0]  time_now,
    input  st_wr_t           st_wr,
    output logic [TS_W-1:0]  ts_q,
    output logic             valid_q,
    output logic             err_q,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [TS_W-1:0]  ts_n;
    logic             valid_w, err_w, valid_n, err_n;
    logic [CNT_W-1:0] cnt_w, cnt_n;

    // host write is applied first; a coincident event then acts on the result
    always_comb begin
        valid_w = st_wr.wr ? (valid_q & st_wr.keep_v) : valid_q;
        err_w   = st_wr.wr ? (err_q & st_wr.keep_e)   : err_q;
        cnt_w   = st_wr.wr ? '0 : cnt_q;
        ts_n    = ts_q;
        valid_n = valid_w;
        err_n   = err_w;
        cnt_n   = cnt_w;
        if (fire) begin
            cnt_n = (cnt_w == CNT_MAX) ? cnt_w : cnt_w + 1'b1;
            if (!valid_w) begin
                ts_n    = time_now;
                valid_n = 1'b1;
            end else begin
                err_n = 1'b1;
                if (overwrite) ts_n = time_now;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ts_q    <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            cnt_q   <= '0;
        end else begin
            ts_q    <= ts_n;
            valid_q <= valid_n;
            err_q   <= err_n;
            cnt_q   <= cnt_n;
        end
    end

    assert_capture_sets_valid_R2: assert property (@(posedge clk) disable iff (rst)
        (fire && !valid_q) |=> valid_q);

    assert_miss_flags_error_R6: assert property (@(posedge clk) disable iff (rst)
        (fire && valid_q && !st_wr.wr) |=> err_q);

    assert_miss_keeps_ts_R6: assert property (@(posedge clk) disable iff (rst)
        (fire && valid_q && !st_wr.wr && !overwrite) |=> $stable(ts_q));

    assert_overwrite_takes_time_R7: assert property (@(posedge clk) disable iff (rst)
        (fire && valid_q && !st_wr.wr && overwrite) |=> (ts_q == $past(time_now)));

    assert_cnt_saturates_R9: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !st_wr.wr) |=> (cnt_q == CNT_MAX));

    assert_write_clears_cnt_R10: assert property (@(posedge clk) disable iff (rst)
        (st_wr.wr && !fire) |=> (cnt_q == '0));

endmodule

// File: rtl/evcap_host_regs.sv
module evcap_host_regs
    import evcap_pkg::*;
#(
    parameter int TS_W   = 32,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [TS_W-1:0]   ts_q,
    input  logic              valid_q,
    input  logic              err_q,
    input  logic [CNT_W-1:0]  cnt_q,
    output cap_cfg_t          cfg_q,
    output logic              src_int_q,
    output st_wr_t            st_wr,
    output logic [DATA_W-1:0] reg_rdata
);
    logic [DATA_W-1:0] status_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            src_int_q <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_CFG)    cfg_q     <= cfg_from_word(reg_wdata);
            if (reg_addr == ADDR_STATUS) src_int_q <= reg_wdata[ST_SRC_INT];
        end
    end

    always_comb begin
        st_wr.wr     = reg_wr && (reg_addr == ADDR_STATUS);
        st_wr.keep_v = reg_wdata[ST_VALID];
        st_wr.keep_e = reg_wdata[ST_ERR];
    end

    always_comb begin
        status_word                          = '0;
        status_word[ST_VALID]                = valid_q;
        status_word[ST_ERR]                  = err_q;
        status_word[ST_SRC_INT]              = src_int_q;
        status_word[ST_CNT_LSB +: CNT_W]     = cnt_q;
    end

    always_comb begin
        case (reg_addr)
            ADDR_STATUS: reg_rdata = status_word;
            ADDR_TS_LO:  reg_rdata = ts_q[DATA_W-1:0];
            ADDR_TS_HI:  reg_rdata = ts_q[TS_W-1:DATA_W];
            ADDR_CFG:    reg_rdata = cfg_to_word(cfg_q);
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/evcap_unit.sv
module evcap_unit
    import evcap_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2*DATA_W-1:0] time_now,
    input  logic                ext_req,
    input  logic                int_trig,
    input  logic [2:0]          reg_addr,
    input  logic                reg_wr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata
);
    localparam int TS_W = 2 * DATA_W;

    cap_cfg_t         cfg_q;
    st_wr_t           st_wr;
    logic             src_int_q;
    logic             src_lvl, edge_pulse, fire;
    logic [TS_W-1:0]  ts_q;
    logic             valid_q, err_q;
    logic [CNT_W-1:0] cnt_q;

    assign src_lvl = src_int_q ? int_trig : ext_req;

    evcap_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .din     (src_lvl),
        .falling (cfg_q.falling),
        .pulse   (edge_pulse)
    );

    assign fire = edge_pulse & cfg_q.armed;

    evcap_capture #(.TS_W(TS_W), .CNT_W(CNT_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .overwrite (cfg_q.overwrite),
        .time_now  (time_now),
        .st_wr     (st_wr),
        .ts_q      (ts_q),
        .valid_q   (valid_q),
        .err_q     (err_q),
        .cnt_q     (cnt_q)
    );

    evcap_host_regs #(.TS_W(TS_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .ts_q      (ts_q),
        .valid_q   (valid_q),
        .err_q     (err_q),
        .cnt_q     (cnt_q),
        .cfg_q     (cfg_q),
        .src_int_q (src_int_q),
        .st_wr     (st_wr),
        .reg_rdata (reg_rdata)
    );

    assert_disarmed_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.armed && !st_wr.wr) |=> ($stable(ts_q) && $stable(valid_q) && $stable(cnt_q)));

    assert_unused_addr_zero_R1: assert property (@(posedge clk) disable iff (rst)
        reg_addr[2] |-> (reg_rdata == '0));

endmodule

// File: tb/evcap_unit_tb_top.sv
module evcap_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] time_now = '0;
    logic        ext_req = 1'b0;
    logic        int_trig = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    evcap_unit dut_i (
        .clk       (clk),
        .rst       (rst),
        .time_now  (time_now),
        .ext_req   (ext_req),
        .int_trig  (int_trig),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    // changes the chosen input, steps the time counter each falling edge,
    // returns the value present at the third rising edge and the status
    // word seen one cycle before it
    task automatic fire_edge(input bit use_int, input bit lvl, input logic [31:0] seed,
                             output logic [31:0] exp_ts, output logic [15:0] pre_w0);
        @(negedge clk);
        if (use_int) int_trig = lvl;
        else         ext_req  = lvl;
        time_now = seed;
        @(negedge clk);
        time_now = seed ^ 32'hA5A5_0F0F;
        @(negedge clk);
        time_now = seed * 32'd2654435761 + 32'd7;
        exp_ts   = time_now;
        rd(3'd0, pre_w0);
        @(negedge clk);
        time_now = ~seed;
    endtask

    task automatic chk_ts(input string req, input logic [31:0] exp);
        logic [15:0] lo, hi;
        rd(3'd1, lo);
        rd(3'd2, hi);
        chk(req, {hi, lo}, exp);
    endtask

    task automatic chk_w0(input string req, input logic [15:0] exp);
        logic [15:0] w;
        rd(3'd0, w);
        chk(req, {16'h0, w}, {16'h0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] d, pre;
        logic [31:0] ts_a, ts_b, ts_x;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values and unused addresses
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R1 reset word", {16'h0, d}, 32'h0);
        end

        wr(3'd3, 16'h0004);
        rd(3'd3, d);
        chk("R2 cfg readback", {16'h0, d}, 32'h4);

        // R2: rising capture on the pin, with latency
        fire_edge(0, 1, 32'h1234_5678, ts_a, pre);
        chk("R2 valid not early", {31'h0, pre[0]}, 32'h0);
        chk_w0("R2 status after capture", 16'h0101);
        chk_ts("R2 timestamp", ts_a);

        // R3: falling edge ignored in rising mode
        fire_edge(0, 0, 32'h0BAD_F00D, ts_x, pre);
        chk_w0("R3 falling ignored", 16'h0101);

        // R6: missed event keeps timestamp, flags error
        fire_edge(0, 1, 32'h7777_0001, ts_x, pre);
        chk_w0("R6 error and count", 16'h0203);
        chk_ts("R6 timestamp kept", ts_a);

        // R8 / R10: clear by writing zeros
        wr(3'd0, 16'h0000);
        chk_w0("R8 R10 cleared", 16'h0000);
        wr(3'd1, 16'hFFFF);
        wr(3'd2, 16'hFFFF);
        chk_ts("R8 ts words read-only", ts_a);

        fire_edge(0, 0, 32'h0000_1111, ts_x, pre);
        fire_edge(0, 1, 32'hCAFE_0042, ts_b, pre);
        chk_w0("R2 recapture", 16'h0101);
        chk_ts("R2 recapture ts", ts_b);
        wr(3'd0, 16'h0003);
        chk_w0("R8 ones keep valid, R10 count cleared", 16'h0001);

        // R7: overwrite mode
        wr(3'd3, 16'h0006);
        fire_edge(0, 0, 32'h0000_2222, ts_x, pre);
        fire_edge(0, 1, 32'h5555_AAAA, ts_b, pre);
        chk_w0("R7 error flagged", 16'h0103);
        chk_ts("R7 timestamp replaced", ts_b);

        // R3: falling mode
        wr(3'd3, 16'h0005);
        wr(3'd0, 16'h0000);
        fire_edge(0, 0, 32'h3141_5926, ts_b, pre);
        chk_w0("R3 falling captured", 16'h0101);
        chk_ts("R3 falling ts", ts_b);
        fire_edge(0, 1, 32'h0000_3333, ts_x, pre);
        chk_w0("R3 rising ignored in falling mode", 16'h0101);

        // R4: internal trigger source
        @(negedge clk);
        int_trig = 1'b1;
        wr(3'd0, 16'h0004);
        chk_w0("R4 source bit", 16'h0004);
        fire_edge(0, 0, 32'h0000_4444, ts_x, pre);
        chk_w0("R4 pin ignored", 16'h0004);
        fire_edge(1, 0, 32'h2718_2818, ts_b, pre);
        chk_w0("R4 internal captured", 16'h0105);
        chk_ts("R4 internal ts", ts_b);
        wr(3'd0, 16'h0000);

        // R5: held level gives one event
        wr(3'd3, 16'h0004);
        fire_edge(0, 1, 32'h0F0F_1234, ts_b, pre);
        repeat (20) @(negedge clk);
        chk_w0("R5 single event", 16'h0101);
        chk_ts("R5 ts", ts_b);

        // R11: disarmed
        wr(3'd3, 16'h0000);
        wr(3'd0, 16'h0000);
        fire_edge(0, 0, 32'h0000_5555, ts_x, pre);
        fire_edge(0, 1, 32'h0000_6666, ts_x, pre);
        chk_w0("R11 no flags or count", 16'h0000);
        chk_ts("R11 ts kept", ts_b);

        // R9: count every edge through saturation
        wr(3'd3, 16'h0004);
        fire_edge(0, 0, 32'h0000_7777, ts_x, pre);
        for (int n = 1; n <= 300; n++) begin
            fire_edge(0, 1, 32'(n), ts_x, pre);
            fire_edge(0, 0, 32'(n), ts_x, pre);
            rd(3'd0, d);
            chk("R9 count", {24'h0, d[15:8]}, (n > 255) ? 32'd255 : 32'(n));
        end
        rd(3'd0, d);
        chk("R9 error after misses", {31'h0, d[1]}, 32'h1);

        // R2: capture sweep across time values
        for (int k = 0; k < 16; k++) begin
            wr(3'd0, 16'h0000);
            fire_edge(0, 1, 32'h1000_0001 * 32'(k + 3), ts_b, pre);
            chk_ts("R2 sweep ts", ts_b);
            fire_edge(0, 0, 32'(k), ts_x, pre);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule